// File: doc/BRIEF.md
# Thermometer Bit Packer

This combinational block takes a W-bit word and returns a word of the same width in which every set input bit has been moved down toward bit 0. The result holds exactly as many ones as the input, packed into the lowest positions with no gaps. Where the ones sat in the input has no effect on the result.

The block first counts the set bits with a balanced adder tree. The tree splits each range of bits at its midpoint, so its depth grows with log2(W). The count is ceil(log2(W+1)) bits wide, so the value W fits. Each output position then compares the count against its own index, which yields a thermometer code.

The block has no clock and no state. The output follows the input within the same cycle. It is meant for places where a serial insertion loop, with an index carried from bit to bit, would make the path too deep.

Top module: `bitpack_therm`

## Requirements
- R1: The number of ones in `dout` always equals the number of ones in `din`.
- R2: The ones in `dout` are contiguous from bit 0: if `dout[i]` is 1 for any i > 0, then `dout[i-1]` is also 1.
- R3: `dout[i]` is 1 exactly when the count of set bits in `din` is greater than i.
- R4: An all-zero `din` gives an all-zero `dout`.
- R5: An all-ones `din` gives an all-ones `dout`, so the internal count can hold the value W.
- R6: `dout` depends only on how many bits of `din` are set: two inputs with the same count but different bit positions give the same `dout`.
- R7: A `din` with exactly one bit set, at any position from 0 to W-1, gives `dout` equal to 1.
- R8: `dout` is a purely combinational function of `din` and settles within the same clock cycle in which `din` changes, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din  | input     | W     | Input word whose set bits are packed |
| dout | output    | W     | Packed word: popcount(din) ones in the lowest positions |

## Verification
All results of this block are due in the same cycle as the stimulus, because there is no register between `din` and `dout`. The driver applies each new word just after a rising clock edge and pushes the expected word into the scoreboard queue. The monitor pops that entry at the following falling edge, half a period later, and compares the output. Each entry is therefore checked before the next word is driven, which also shows that the block adds no latency (R8). The expected word comes from a reference loop that appends each set input bit at a running position.

// File: rtl/bitpack_pkg.sv
package bitpack_pkg;

    // Legal range of the word width
    localparam int BP_W_MIN = 4;
    localparam int BP_W_MAX = 64;
    localparam int BP_W_DEF = 32;

    // Width needed to hold a count of 0..n
    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

    // Split point of a balanced tree node covering n leaves
    function automatic int split_lo(input int n);
        return n / 2;
    endfunction

endpackage

// File: rtl/bitpack_popcnt.sv
module bitpack_popcnt
    import bitpack_pkg::*;
#(
    parameter int N = 4,
    localparam int CW = cnt_width(N)
) (
    input  logic [N-1:0]  bits,
    output logic [CW-1:0] cnt
);

    generate
        if (N == 1) begin : g_leaf
            // A single bit is its own count
            always_comb cnt = CW'(bits[0]);
        end else begin : g_node
            localparam int NLO  = split_lo(N);
            localparam int NHI  = N - NLO;
            localparam int CWLO = cnt_width(NLO);
            localparam int CWHI = cnt_width(NHI);

            logic [CWLO-1:0] cnt_lo;
            logic [CWHI-1:0] cnt_hi;

            bitpack_popcnt #(.N(NLO)) u_lo (
                .bits (bits[NLO-1:0]),
                .cnt  (cnt_lo)
            );

            bitpack_popcnt #(.N(NHI)) u_hi (
                .bits (bits[N-1:NLO]),
                .cnt  (cnt_hi)
            );

            // Both halves zero-extend to the parent width before the add
            always_comb cnt = CW'(cnt_lo) + CW'(cnt_hi);
        end
    endgenerate

endmodule

// File: rtl/bitpack_therm_dec.sv
module bitpack_therm_dec
    import bitpack_pkg::*;
#(
    parameter int W = BP_W_DEF,
    localparam int CW = cnt_width(W)
) (
    input  logic [CW-1:0] cnt,
    output logic [W-1:0]  therm
);

    // Every position compares the count against its own index
    for (genvar i = 0; i < W; i++) begin : g_pos
        assign therm[i] = (cnt > CW'(i));
    end

endmodule

// File: rtl/bitpack_therm.sv
module bitpack_therm
    import bitpack_pkg::*;
#(
    parameter int W = BP_W_DEF
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    localparam int CW = cnt_width(W);

    generate
        if (W < BP_W_MIN || W > BP_W_MAX) begin : g_bad_w
            $error("bitpack_therm: W out of supported range");
        end
    endgenerate

    logic [CW-1:0] ones_cnt;

    bitpack_popcnt #(.N(W)) u_cnt (
        .bits (din),
        .cnt  (ones_cnt)
    );

    bitpack_therm_dec #(.W(W)) u_dec (
        .cnt   (ones_cnt),
        .therm (dout)
    );

endmodule

// File: rtl/bitpack_therm_chk.sv
module bitpack_therm_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] din,
    input logic [W-1:0] dout
);

    logic [W:0] inc_out;
    assign inc_out = {1'b0, dout} + 1'b1;

    always_comb begin
        p_ones_kept_r1: assert ($countones(dout) == $countones(din));
        // Thermometer shape: dout+1 shares no bit with dout
        p_contig_r2: assert ((inc_out & {1'b0, dout}) == '0);
        p_zero_in_r4: assert (!(din == '0) || dout == '0);
        p_full_in_r5: assert (!(&din) || (&dout));
        p_single_r7: assert (!($countones(din) == 1) || dout == W'(1));
        for (int i = 0; i < W; i++) begin
            p_pos_cmp_r3: assert (dout[i] == ($countones(din) > i));
        end
    end

endmodule

bind bitpack_therm bitpack_therm_chk #(.W(W)) u_chk (
    .din  (din),
    .dout (dout)
);

// File: tb/bitpack_therm_tb.sv
module bitpack_therm_tb;

    localparam int W = 32;
    localparam int WATCHDOG = 100000;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    item_t sb[$];
    logic [W-1:0] keep_a;

    always #10 clk = ~clk;

    bitpack_therm #(.W(W)) u_dut (
        .din  (din),
        .dout (dout)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] v);
        logic [W-1:0] r = '0;
        int pos = 0;
        for (int i = 0; i < W; i++) begin
            if (v[i]) begin
                r[pos] = 1'b1;
                pos++;
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] v, input string tag);
        item_t it;
        @(posedge clk);
        din = v;
        it.exp = model(v);
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: result is due half a period after the drive (R8)
    always @(negedge clk) begin
        if (!rst && sb.size() > 0) begin
            item_t it;
            logic [W:0] t;
            it = sb.pop_front();
            check({it.tag, " R8"}, dout, it.exp);
            t = {1'b0, dout} + 1'b1;
            check("R2 contiguous", W'(t[W-1:0] & dout), '0);
            check("R1 count", W'($countones(dout)), W'($countones(din)));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R4 reset state", dout, '0);

        drive('0, "R4 all zero");
        drive('1, "R5 all ones");
        for (int i = 0; i < W; i++)
            drive(W'(1) << i, "R7 single bit");
        drive(32'h8000_0001, "R3 ends");
        drive(32'h0000_FFFF, "R3 low half");
        drive(32'hFFFF_0000, "R3 high half");
        drive(32'hAAAA_AAAA, "R3 alternating");
        drive(32'h7FFF_FFFE, "R3 W-2 bits");
        for (int i = 0; i < 300; i++)
            drive($urandom, "R3 random");
        @(negedge clk);

        // R6: same count at different positions yields same output
        for (int k = 1; k < W; k += 5) begin
            @(posedge clk);
            din = (W'(1) << k) - 1'b1;
            @(negedge clk);
            keep_a = dout;
            @(posedge clk);
            din = ~('1 >> k);
            @(negedge clk);
            check("R6 position independence", dout, keep_a);
        end

        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule